// File: doc/BRIEF.md
# Two-Wire Serial Command Master

This block runs transactions on a two-wire serial link made of a clock and one bidirectional data line. A host loads a command word, which holds an opcode and two bit counts, and up to 64 bits of left-aligned command data through a small write port. The engine then sends a low start bit and the command bits, MSB first and inverted on the wire. It clocks a fixed run of idle periods and hands the data line to the slave through a direction output for an external transceiver. It then hunts for the slave's low start bit.

Once the start bit arrives, the engine captures a 4-bit tag. If the tag's low three bits are zero and a response length was requested, it captures up to 32 data bits. It always captures a 4-bit check field, which it stores and does not verify. Every received field is inverted before storage. The engine then publishes a status code, takes the line back, and clocks a trailing idle run before it accepts more work. A wait for the start bit that exceeds a fixed number of periods ends the transaction with a timeout status.

The bit period is set by a clock-divider parameter. The host sees the command word, the status, the tag, the check field and the response data as registered outputs.

Top module: `serial_cmd_master`

## Requirements
- R1: After reset the status reads 0x00, the link clock is high, the data line is driven (dat_drive_o = 1) high, and the command word reads 0.
- R2: Command word fields: bits 7:0 opcode (0 none, 1 send, 2 break), bits 15:8 command length in bits, bits 23:16 response length in bits, bits 31:24 unused. Write addresses: 0 command word, 1 first data word (sent first), 2 second data word. One cycle after a non-zero opcode is written, status reads 0x01 and bits 7:0 of the command word read 0.
- R3: An opcode other than 0, 1 or 2 gives status 0x80 two cycles after the write, and the link clock does not toggle.
- R4: Opcode 2 gives status 0x02 two cycles after the write, and the link clock does not toggle.
- R5: A write to the command word while status is 0x01 has no effect: the command word is unchanged and no further transaction starts.
- R6: A send frame places one low start bit on the wire, then the number of command bits given by the length field (clamped to 64). These bits are taken MSB first from {first word, second word}, and each is inverted on the wire.
- R7: Each bit period holds the link clock low for HALF_DIV cycles and then high for HALF_DIV cycles. The clock idles high. Outgoing data is stable at the rising edge, and input is sampled in the last low cycle.
- R8: After the command bits, 16 periods are clocked with data high. The data line is then released (dat_drive_o = 0), and the output value reads high while released.
- R9: In each released period a wire low counts as the start bit. If none has been seen after 1000 periods, status becomes 0x82, the tag, check and data registers keep their values, and the trailing delay follows at once.
- R10: The 4 bits after the start bit are stored inverted, MSB first, as the tag. When the tag's bits 2:0 are non-zero, no data bits are read and the response data register keeps its value.
- R11: When the tag's bits 2:0 are zero and the response length is non-zero, that many bits (clamped to 32) are read MSB first. They are stored inverted and right-aligned, with unused upper bits reading 1. A response length of 0 reads no data.
- R12: The 4 bits that follow are always stored inverted as the check field, and status becomes 0x02.
- R13: After every send, including a timeout, the data line is driven high again and 16 more periods are clocked. The engine then idles with the clock high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 2 | Register select: 0 command, 1 first data word, 2 second data word |
| host_wdata | input | 32 | Write data |
| cmd_word_o | output | 32 | Command word readback |
| status_o | output | 8 | Status code |
| rsp_tag_o | output | 4 | Captured tag, inverted from wire |
| rsp_chk_o | output | 4 | Captured check field, inverted from wire |
| rsp_data_o | output | 32 | Captured response data, right-aligned |
| link_clk_o | output | 1 | Link clock, idles high |
| link_dat_o | output | 1 | Link data output value |
| dat_drive_o | output | 1 | Data direction: 1 drive, 0 receive (transceiver control) |
| link_dat_i | input | 1 | Link data as seen on the wire |

## Verification
A command write lands in the register on edge E. The accept result (status 0x01, opcode cleared) is due after edge E+1, and the break or invalid outcome after edge E+2. The bench samples these at the falling clock edges that follow exactly those edges. Wire activity is sampled at the rising edges of the link clock itself, where outgoing data has been stable for HALF_DIV cycles. The bench's slave model changes its bit one nanosecond after each link-clock fall, which leaves a full core cycle before the sampling edge. Final status and captured fields are read only after sixteen trailing rising edges have been counted and status has left 0x01.

// File: rtl/scm_pkg.sv
package scm_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_DISPATCH, ST_TX_START, ST_TX_BITS, ST_ECHO,
    ST_WAIT, ST_TAG, ST_DATA, ST_CHK, ST_TRAIL
  } scm_state_e;

  localparam logic [7:0] STS_IDLE    = 8'h00;
  localparam logic [7:0] STS_SENDING = 8'h01;
  localparam logic [7:0] STS_DONE    = 8'h02;
  localparam logic [7:0] STS_BAD_CMD = 8'h80;
  localparam logic [7:0] STS_TIMEOUT = 8'h82;

  localparam logic [7:0] OP_NONE  = 8'h00;
  localparam logic [7:0] OP_SEND  = 8'h01;
  localparam logic [7:0] OP_BREAK = 8'h02;

  localparam logic [1:0] ADDR_CMD = 2'd0;
  localparam logic [1:0] ADDR_DW0 = 2'd1;
  localparam logic [1:0] ADDR_DW1 = 2'd2;
endpackage

// File: rtl/scm_bit_timer.sv
// Bit-period phase generator. HALF_DIV must be at least 2 so the sample
// tick and the end-of-period tick fall in different cycles.
module scm_bit_timer #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic low_phase,
  output logic smp_tick,
  output logic end_tick
);
  localparam int PERIOD = 2 * HALF_DIV;
  localparam int CW = $clog2(PERIOD);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt == CW'(PERIOD - 1)) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  // Registered clock output lags cnt by one cycle, so the pin is low while
  // cnt is 1..HALF_DIV; the cycle with cnt == HALF_DIV is the last low one.
  assign low_phase = run && (cnt < CW'(HALF_DIV));
  assign smp_tick  = run && (cnt == CW'(HALF_DIV));
  assign end_tick  = run && (cnt == CW'(PERIOD - 1));
endmodule

// File: rtl/scm_tx_shift.sv
module scm_tx_shift #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         msb
);
  logic [W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else if (load) sr <= load_val;
    else if (shift) sr <= {sr[W-2:0], 1'b0};
  end

  assign msb = sr[W-1];
endmodule

// File: rtl/scm_rx_shift.sv
module scm_rx_shift #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         shift,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clear) q <= '0;
    else if (shift) q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/serial_cmd_master.sv
module serial_cmd_master
  import scm_pkg::*;
#(
  parameter int REG_W      = 32,
  parameter int HALF_DIV   = 2,
  parameter int IDLE_CLKS  = 16,
  parameter int START_WAIT = 1000,
  parameter int TAG_W      = 4,
  parameter int CHK_W      = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_we,
  input  logic [1:0]       host_addr,
  input  logic [REG_W-1:0] host_wdata,
  output logic [REG_W-1:0] cmd_word_o,
  output logic [7:0]       status_o,
  output logic [TAG_W-1:0] rsp_tag_o,
  output logic [CHK_W-1:0] rsp_chk_o,
  output logic [REG_W-1:0] rsp_data_o,
  output logic             link_clk_o,
  output logic             link_dat_o,
  output logic             dat_drive_o,
  input  logic             link_dat_i
);
  localparam int AREA_W = 2 * REG_W;
  localparam int RSP_W  = REG_W;
  localparam int MAX_A  = (START_WAIT > AREA_W) ? START_WAIT : AREA_W;
  localparam int MAX_N  = (MAX_A > IDLE_CLKS) ? MAX_A : IDLE_CLKS;
  localparam int CNT_W  = $clog2(MAX_N + 1);

  scm_state_e state;
  logic [REG_W-1:0] cmd_q, dw0_q, dw1_q, rsp_q;
  logic [7:0]       status_q, op_q;
  logic [CNT_W-1:0] bits_left, clen_q, rlen_q;
  logic [TAG_W-1:0] tag_q;
  logic [CHK_W-1:0] chk_q;
  logic             start_seen;
  logic             clk_q, dat_q, drv_q;

  logic             accept, bus_run, low_phase, smp_tick, end_tick;
  logic             tx_msb, rx_clear, rx_shift, last_bit, receiving;
  logic [RSP_W-1:0] rx_q;
  logic [7:0]       clen_f, rlen_f;

  assign accept    = (state == ST_IDLE) && (cmd_q[7:0] != OP_NONE);
  assign bus_run   = (state != ST_IDLE) && (state != ST_DISPATCH);
  assign last_bit  = (bits_left == CNT_W'(1));
  assign receiving = (state == ST_WAIT) || (state == ST_TAG) ||
                     (state == ST_DATA) || (state == ST_CHK);
  assign clen_f    = cmd_q[15:8];
  assign rlen_f    = cmd_q[23:16];

  scm_bit_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk(clk), .rst(rst), .run(bus_run),
    .low_phase(low_phase), .smp_tick(smp_tick), .end_tick(end_tick)
  );

  scm_tx_shift #(.W(AREA_W)) u_tx (
    .clk(clk), .rst(rst),
    .load(state == ST_DISPATCH), .load_val({dw0_q, dw1_q}),
    .shift(end_tick && (state == ST_TX_BITS)), .msb(tx_msb)
  );

  assign rx_shift = smp_tick && ((state == ST_TAG) || (state == ST_DATA) || (state == ST_CHK));
  assign rx_clear = end_tick && ((state == ST_WAIT) ||
                    (((state == ST_TAG) || (state == ST_DATA)) && last_bit));

  scm_rx_shift #(.W(RSP_W)) u_rx (
    .clk(clk), .rst(rst), .clear(rx_clear), .shift(rx_shift),
    .din(link_dat_i), .q(rx_q)
  );

  // Host register file; clearing the opcode on accept wins over a write.
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
      dw0_q <= '0;
      dw1_q <= '0;
    end else begin
      if (host_we && host_addr == ADDR_DW0) dw0_q <= host_wdata;
      if (host_we && host_addr == ADDR_DW1) dw1_q <= host_wdata;
      if (accept) cmd_q[7:0] <= OP_NONE;
      else if (host_we && host_addr == ADDR_CMD && status_q != STS_SENDING)
        cmd_q <= host_wdata;
    end
  end

  // Transaction sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      status_q   <= STS_IDLE;
      op_q       <= OP_NONE;
      clen_q     <= '0;
      rlen_q     <= '0;
      bits_left  <= '0;
      tag_q      <= '0;
      chk_q      <= '0;
      rsp_q      <= '0;
      start_seen <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          status_q <= STS_SENDING;
          op_q     <= cmd_q[7:0];
          clen_q   <= (int'(clen_f) > AREA_W) ? CNT_W'(AREA_W) : CNT_W'(clen_f);
          rlen_q   <= (int'(rlen_f) > RSP_W) ? CNT_W'(RSP_W) : CNT_W'(rlen_f);
          state    <= ST_DISPATCH;
        end
        ST_DISPATCH: begin
          if (op_q == OP_SEND) state <= ST_TX_START;
          else begin
            status_q <= (op_q == OP_BREAK) ? STS_DONE : STS_BAD_CMD;
            state    <= ST_IDLE;
          end
        end
        ST_TX_START: if (end_tick) begin
          if (clen_q != '0) begin
            state     <= ST_TX_BITS;
            bits_left <= clen_q;
          end else begin
            state     <= ST_ECHO;
            bits_left <= CNT_W'(IDLE_CLKS);
          end
        end
        ST_TX_BITS: if (end_tick) begin
          if (last_bit) begin
            state     <= ST_ECHO;
            bits_left <= CNT_W'(IDLE_CLKS);
          end else bits_left <= bits_left - 1'b1;
        end
        ST_ECHO: if (end_tick) begin
          if (last_bit) begin
            state     <= ST_WAIT;
            bits_left <= CNT_W'(START_WAIT);
          end else bits_left <= bits_left - 1'b1;
        end
        ST_WAIT: begin
          if (smp_tick) start_seen <= !link_dat_i;
          if (end_tick) begin
            if (start_seen) begin
              state     <= ST_TAG;
              bits_left <= CNT_W'(TAG_W);
            end else if (last_bit) begin
              status_q  <= STS_TIMEOUT;
              state     <= ST_TRAIL;
              bits_left <= CNT_W'(IDLE_CLKS);
            end else bits_left <= bits_left - 1'b1;
          end
        end
        ST_TAG: if (end_tick) begin
          if (last_bit) begin
            tag_q <= ~rx_q[TAG_W-1:0];
            if (rx_q[TAG_W-2:0] == {(TAG_W-1){1'b1}} && rlen_q != '0) begin
              state     <= ST_DATA;
              bits_left <= rlen_q;
            end else begin
              state     <= ST_CHK;
              bits_left <= CNT_W'(CHK_W);
            end
          end else bits_left <= bits_left - 1'b1;
        end
        ST_DATA: if (end_tick) begin
          if (last_bit) begin
            rsp_q     <= ~rx_q;
            state     <= ST_CHK;
            bits_left <= CNT_W'(CHK_W);
          end else bits_left <= bits_left - 1'b1;
        end
        ST_CHK: if (end_tick) begin
          if (last_bit) begin
            chk_q     <= ~rx_q[CHK_W-1:0];
            status_q  <= STS_DONE;
            state     <= ST_TRAIL;
            bits_left <= CNT_W'(IDLE_CLKS);
          end else bits_left <= bits_left - 1'b1;
        end
        ST_TRAIL: if (end_tick) begin
          if (last_bit) state <= ST_IDLE;
          else bits_left <= bits_left - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Registered pin drivers
  always_ff @(posedge clk) begin
    if (rst) begin
      clk_q <= 1'b1;
      dat_q <= 1'b1;
      drv_q <= 1'b1;
    end else begin
      clk_q <= !low_phase;
      drv_q <= !receiving;
      if (state == ST_TX_START) dat_q <= 1'b0;
      else if (state == ST_TX_BITS) dat_q <= ~tx_msb;
      else dat_q <= 1'b1;
    end
  end

  assign cmd_word_o  = cmd_q;
  assign status_o    = status_q;
  assign rsp_tag_o   = tag_q;
  assign rsp_chk_o   = chk_q;
  assign rsp_data_o  = rsp_q;
  assign link_clk_o  = clk_q;
  assign link_dat_o  = dat_q;
  assign dat_drive_o = drv_q;
endmodule

// File: rtl/scm_checker.sv
module scm_checker
  import scm_pkg::*;
#(
  parameter int REG_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             host_we,
  input logic [1:0]       host_addr,
  input logic [REG_W-1:0] cmd_word_o,
  input logic [7:0]       status_o,
  input logic             link_clk_o,
  input logic             link_dat_o,
  input logic             dat_drive_o
);
  // R5: command word frozen while a transaction is running
  assert_cmd_locked_R5: assert property (@(posedge clk) disable iff (rst)
    (host_we && host_addr == ADDR_CMD && status_o == STS_SENDING) |=> $stable(cmd_word_o));

  // R2: entering the sending status coincides with the opcode being cleared
  assert_code_cleared_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(status_o == STS_SENDING) |-> (cmd_word_o[7:0] == OP_NONE));

  // R2: a status that is not "sending" can only change to "sending"
  assert_status_entry_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(status_o) != STS_SENDING && status_o != $past(status_o)) |-> (status_o == STS_SENDING));

  // R8: released data line reads high
  assert_release_high_R8: assert property (@(posedge clk) disable iff (rst)
    !dat_drive_o |-> link_dat_o);

  // R1, R3: idle or rejected command keeps the link clock high
  assert_quiet_clock_R3: assert property (@(posedge clk) disable iff (rst)
    (status_o == STS_IDLE || status_o == STS_BAD_CMD) |-> link_clk_o);
endmodule

bind serial_cmd_master scm_checker #(.REG_W(REG_W)) u_scm_checker (
  .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
  .cmd_word_o(cmd_word_o), .status_o(status_o), .link_clk_o(link_clk_o),
  .link_dat_o(link_dat_o), .dat_drive_o(dat_drive_o)
);

// File: tb/serial_cmd_master_test.sv
`timescale 1ns/1ps
module serial_cmd_master_test;
  localparam int CLK_NS   = 8;
  localparam int HALF     = 2;
  localparam int WD_LIMIT = 150000;

  typedef struct packed {
    logic [7:0]  clen;
    logic [7:0]  rlen;
    logic [31:0] w0;
    logic [31:0] w1;
    logic [7:0]  dly;
    logic [3:0]  tag;
    logic [31:0] rdat;
    logic [3:0]  chk;
    logic        tmo;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{8'd8,  8'd8,  32'hA500_0000, 32'h0,          8'd3,  4'h8, 32'h0000_003C, 4'h9, 1'b0},
    '{8'd40, 8'd32, 32'h1234_5678, 32'h9A00_0000,  8'd0,  4'h0, 32'hDEAD_BEEF, 4'h5, 1'b0},
    '{8'd21, 8'd16, 32'hFFFF_F800, 32'h0,          8'd10, 4'h3, 32'h0000_1234, 4'hA, 1'b0},
    '{8'd32, 8'd0,  32'h8000_0001, 32'h0,          8'd1,  4'h0, 32'h0000_00FF, 4'hF, 1'b0},
    '{8'd64, 8'd1,  32'h0F0F_0F0F, 32'hF0F0_F0F0,  8'd2,  4'h0, 32'h0000_0001, 4'h0, 1'b0},
    '{8'd4,  8'd8,  32'hC000_0000, 32'h0,          8'd0,  4'h0, 32'h0,         4'h0, 1'b1}
  };

  logic clk = 0, rst = 1;
  logic host_we = 0;
  logic [1:0] host_addr = 0;
  logic [31:0] host_wdata = 0;
  logic [31:0] cmd_word_o, rsp_data_o;
  logic [7:0] status_o;
  logic [3:0] rsp_tag_o, rsp_chk_o;
  logic link_clk_o, link_dat_o, dat_drive_o;
  logic link_dat_i = 1;

  serial_cmd_master uut (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .cmd_word_o(cmd_word_o), .status_o(status_o),
    .rsp_tag_o(rsp_tag_o), .rsp_chk_o(rsp_chk_o), .rsp_data_o(rsp_data_o),
    .link_clk_o(link_clk_o), .link_dat_o(link_dat_o), .dat_drive_o(dat_drive_o),
    .link_dat_i(link_dat_i)
  );

  always #(CLK_NS/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic wd_hit = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= WD_LIMIT) wd_hit <= 1'b1;
  end

  // Wire monitor
  logic tx_log [0:127];
  int n_tx, n_trail, lo_min, lo_max;
  logic seen_rx = 0, mon_on = 0;
  time t_neg;
  always @(negedge link_clk_o) t_neg = $time;
  always @(posedge link_clk_o) begin
    if (mon_on) begin
      int lw;
      lw = int'(($time - t_neg) / CLK_NS);
      if (lw < lo_min) lo_min = lw;
      if (lw > lo_max) lo_max = lw;
      if (dat_drive_o) begin
        if (!seen_rx) begin
          if (n_tx < 128) tx_log[n_tx] = link_dat_o;
          n_tx++;
        end else n_trail++;
      end else seen_rx = 1;
    end
  end

  // Slave model: changes its bit just after each link clock fall
  int rx_k, sl_nd, sl_dly;
  logic [3:0] sl_tag, sl_chk;
  logic [31:0] sl_rdat;
  logic sl_tmo;

  function automatic logic resp_bit(int k);
    int j;
    if (sl_tmo) return 1'b1;
    if (k < sl_dly) return 1'b1;
    if (k == sl_dly) return 1'b0;
    j = k - sl_dly - 1;
    if (j < 4) return ~sl_tag[3-j];
    j = j - 4;
    if (j < sl_nd) return ~sl_rdat[sl_nd-1-j];
    j = j - sl_nd;
    if (j < 4) return ~sl_chk[3-j];
    return 1'b1;
  endfunction

  always @(negedge link_clk_o) begin
    #1;
    if (!dat_drive_o) begin
      link_dat_i = resp_bit(rx_k);
      rx_k++;
    end else link_dat_i = 1'b1;
  end

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic mon_reset();
    n_tx = 0; n_trail = 0; seen_rx = 0; rx_k = 0;
    lo_min = 1000; lo_max = 0; mon_on = 1;
  endtask

  task automatic wait_done();
    while (!(status_o != 8'h01 && n_trail >= 16) && !wd_hit) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic count_quiet(input int n, output int lows);
    lows = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (link_clk_o !== 1'b1) lows++;
    end
  endtask

  logic [31:0] exp_data = 0;
  logic [3:0]  exp_tag = 0, exp_chk = 0;

  task automatic run_vec(input vec_t v);
    logic [63:0] area;
    int bad, nd, rl;
    logic [31:0] m;
    mon_reset();
    sl_tmo = v.tmo; sl_dly = int'(v.dly); sl_tag = v.tag; sl_chk = v.chk; sl_rdat = v.rdat;
    rl = (v.rlen > 32) ? 32 : int'(v.rlen);
    nd = (v.tag[2:0] == 3'b000) ? rl : 0;
    sl_nd = nd;
    host_write(2'd1, v.w0);
    host_write(2'd2, v.w1);
    host_write(2'd0, {8'h00, v.rlen, v.clen, 8'h01});
    @(negedge clk);
    check("R2", "accept status", 64'(status_o), 64'h01);
    check("R2", "opcode cleared", 64'(cmd_word_o), 64'({8'h00, v.rlen, v.clen, 8'h00}));
    wait_done();
    area = {v.w0, v.w1};
    check("R6", "frame length", 64'(n_tx), 64'(1 + int'(v.clen) + 16));
    check("R6", "start bit", 64'(tx_log[0]), 64'h0);
    bad = 0;
    for (int i = 1; i <= int'(v.clen); i++) if (tx_log[i] !== ~area[64-i]) bad++;
    check("R6", "command bits", 64'(bad), 64'h0);
    bad = 0;
    for (int i = int'(v.clen) + 1; i <= int'(v.clen) + 16; i++) if (tx_log[i] !== 1'b1) bad++;
    check("R8", "echo idle bits", 64'(bad), 64'h0);
    check("R7", "low width min", 64'(lo_min), 64'(HALF));
    check("R7", "low width max", 64'(lo_max), 64'(HALF));
    if (v.tmo) begin
      check("R9", "timeout status", 64'(status_o), 64'h82);
    end else begin
      exp_tag = v.tag;
      exp_chk = v.chk;
      if (nd > 0) begin
        m = (nd >= 32) ? 32'hFFFF_FFFF : ((32'd1 << nd) - 32'd1);
        exp_data = ~m | (v.rdat & m);
      end
      check("R12", "done status", 64'(status_o), 64'h02);
    end
    check("R10", "tag", 64'(rsp_tag_o), 64'(exp_tag));
    check("R11", "response data", 64'(rsp_data_o), 64'(exp_data));
    check("R12", "check field", 64'(rsp_chk_o), 64'(exp_chk));
    check("R13", "trailing clocks", 64'(n_trail), 64'd16);
    check("R13", "idle pins", 64'({link_clk_o, link_dat_o, dat_drive_o}), 64'b111);
    mon_on = 0;
  endtask

  initial begin
    int lows;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1", "status", 64'(status_o), 64'h00);
    check("R1", "pins", 64'({link_clk_o, link_dat_o, dat_drive_o}), 64'b111);
    check("R1", "command word", 64'(cmd_word_o), 64'h0);

    // R3 unknown opcode
    host_write(2'd0, 32'h0000_0805);
    @(negedge clk);
    check("R2", "accept status", 64'(status_o), 64'h01);
    @(negedge clk);
    check("R3", "invalid status", 64'(status_o), 64'h80);
    count_quiet(40, lows);
    check("R3", "clock quiet", 64'(lows), 64'h0);

    // R4 break
    host_write(2'd0, 32'h0000_0002);
    @(negedge clk);
    check("R2", "opcode cleared", 64'(cmd_word_o), 64'h0);
    @(negedge clk);
    check("R4", "break status", 64'(status_o), 64'h02);
    count_quiet(40, lows);
    check("R4", "clock quiet", 64'(lows), 64'h0);

    for (int i = 0; i < NV; i++) if (!wd_hit) run_vec(VECS[i]);

    // R5 write while busy
    mon_reset();
    sl_tmo = 0; sl_dly = 2; sl_tag = 4'h0; sl_chk = 4'h3; sl_rdat = 32'h5A; sl_nd = 8;
    host_write(2'd1, 32'hF000_0000);
    host_write(2'd0, 32'h0008_0801);
    repeat (20) @(negedge clk);
    host_write(2'd0, 32'h0010_1001);
    @(negedge clk);
    check("R5", "busy write ignored", 64'(cmd_word_o), 64'h0008_0800);
    wait_done();
    check("R5", "status after busy write", 64'(status_o), 64'h02);
    check("R11", "busy frame data", 64'(rsp_data_o), 64'hFFFF_FF5A);
    mon_on = 0;
    count_quiet(80, lows);
    check("R5", "no second transaction", 64'(lows), 64'h0);
    check("R5", "command word kept", 64'(cmd_word_o), 64'h0008_0800);

    if (wd_hit) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WD_LIMIT);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule